// File: doc/BRIEF.md
# Low-Speed Domain Clock Control Register

This block is the single 32-bit control and status word of a battery-backed, low-speed clock domain. Software reaches it through a plain synchronous port. A write replaces every writable field at once. A read returns the whole word one cycle after it is requested. The register drives the control lines of a 32 kHz external crystal oscillator: enable, bypass and drive strength. It also drives the real-time-clock source select and its enable, the clock-monitor enable, a software reset for the whole domain, and the enable and select of a low-speed clock output pin.

The block does more than store values. The clock source select can be written only once. A set monitor enable cannot be cleared by software until a clock failure has been recorded. The bypass bit accepts writes only while the oscillator is fully off. The ready flag tracks the oscillator's stable indication. When the oscillator is switched off, the ready flag drops only after six rising edges of the oscillator clock, counted after that clock has been brought into the register clock domain. A failure detector outside the block reports through a one-cycle pulse. The block keeps the result as a sticky flag.

Top module: `lsd_ctrl_reg`

## Requirements
- R1: After reset every bit of the word reads 0 and every control output is 0.
- R2: Field positions: bit 0 oscillator enable, bit 1 ready (read-only), bit 2 bypass, bits 4:3 drive strength, bit 5 monitor enable, bit 6 failure flag (read-only), bits 9:8 source select, bit 15 clock enable, bit 16 domain reset, bit 24 output enable, bit 25 output select. All other bits read 0 and ignore writes.
- R3: When rd_en is high in a cycle, rd_data shows the word as it was in that cycle, starting from the next cycle. rd_data holds its value while rd_en is low.
- R4: The ready flag (bit 1) rises one cycle after the oscillator enable is 1 and osc_stable_i is 1. It never rises while the enable is 0.
- R5: After the enable is cleared, ready stays 1 through five synchronized rising edges of lsclk_i. It falls on the sixth edge. Setting the enable again before then restarts the count.
- R6: Bypass (bit 2) takes a written value only when the enable and ready are both 0 at the time of the write. Otherwise it keeps its value.
- R7: Source select codes are 0 none, 1 external low-speed oscillator, 2 internal low-speed oscillator, 3 divided high-speed oscillator. Once the field is nonzero, writes to it are ignored.
- R8: While the failure flag is 1, the source select accepts writes again.
- R9: Once the monitor enable (bit 5) is 1, a write of 0 to it takes effect only if the failure flag is 1.
- R10: The failure flag is set by fail_pulse_i only while the monitor enable is 1. It stays set until a domain reset. Software writes to bit 6 have no effect.
- R11: A write with bit 16 set clears every other field, including ready, the failure flag and the source lock, from the next cycle on. While bit 16 reads 1, writes to all other fields are ignored.
- R12: Each control output equals the field of the same meaning in the word: osc_en_o bit 0, osc_byp_o bit 2, osc_drv_o bits 4:3, mon_en_o bit 5, rtc_src_o bits 9:8, rtc_en_o bit 15, dom_rst_o bit 16, lsout_en_o bit 24, lsout_sel_o bit 25.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the whole word |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | 32 | Read data, valid the cycle after rd_en |
| osc_stable_i | input | 1 | Stable indication from the external oscillator |
| lsclk_i | input | 1 | External low-speed oscillator clock, asynchronous |
| fail_pulse_i | input | 1 | One-cycle failure detect pulse |
| osc_en_o | output | 1 | Oscillator enable |
| osc_byp_o | output | 1 | Oscillator bypass |
| osc_drv_o | output | 2 | Oscillator drive strength |
| mon_en_o | output | 1 | Clock monitor enable |
| rtc_src_o | output | 2 | Real-time-clock source select |
| rtc_en_o | output | 1 | Real-time-clock enable |
| dom_rst_o | output | 1 | Domain software reset |
| lsout_en_o | output | 1 | Low-speed clock output enable |
| lsout_sel_o | output | 1 | Low-speed clock output select |

## Verification
A lock or guard bit held in the wrong state shows up at the next read. The source select or bypass bit then reads differently from what was written, or it changes when it should not. The same wrong value appears on rtc_src_o or osc_byp_o in the cycle after the write. A fault in the fall counter shifts the cycle in which bit 1 drops. The bench therefore reads the word after each synchronized lsclk_i edge, so a count off by one edge is caught within that edge's window. A failure flag that is not sticky, or that is captured without the monitor enabled, is visible in bit 6 at the first read after the pulse.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  localparam int REG_W       = 32;
  localparam int BIT_OSC_EN  = 0;
  localparam int BIT_RDY     = 1;
  localparam int BIT_BYP     = 2;
  localparam int DRV_LSB     = 3;
  localparam int BIT_MON     = 5;
  localparam int BIT_FAIL    = 6;
  localparam int SRC_LSB     = 8;
  localparam int BIT_RTC_EN  = 15;
  localparam int BIT_DOM_RST = 16;
  localparam int BIT_LSO_EN  = 24;
  localparam int BIT_LSO_SEL = 25;

  typedef enum logic [1:0] {
    SRC_NONE   = 2'd0,
    SRC_EXT_LS = 2'd1,
    SRC_INT_LS = 2'd2,
    SRC_HS_DIV = 2'd3
  } rtc_src_e;

  typedef struct packed {
    logic       lso_sel;
    logic       lso_en;
    logic       dom_rst;
    logic       rtc_en;
    rtc_src_e   src;
    logic       fail;
    logic       mon_en;
    logic [1:0] drv;
    logic       byp;
    logic       osc_en;
  } ctl_fields_t;
endpackage

// File: rtl/lsd_edge_sync.sv
module lsd_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic rise_o
);
  localparam int SR_W = STAGES + 1;

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;

  always_comb begin
    sr_d = {sr_q[SR_W-2:0], async_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign rise_o = sr_q[STAGES-1] & ~sr_q[STAGES];
endmodule

// File: rtl/lsd_ready_track.sv
module lsd_ready_track #(
  parameter int FALL_EDGES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic osc_en_i,
  input  logic stable_i,
  input  logic ls_rise_i,
  output logic rdy_o
);
  localparam int CW = $clog2(FALL_EDGES + 1);
  localparam logic [CW-1:0] LAST = CW'(FALL_EDGES - 1);

  logic          rdy_q, rdy_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    rdy_d = rdy_q;
    cnt_d = cnt_q;
    if (clear_i) begin
      rdy_d = 1'b0;
      cnt_d = '0;
    end else if (osc_en_i) begin
      cnt_d = '0;
      if (stable_i) rdy_d = 1'b1;
    end else if (rdy_q && ls_rise_i) begin
      if (cnt_q == LAST) begin
        rdy_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      rdy_q <= rdy_d;
      cnt_q <= cnt_d;
    end
  end

  assign rdy_o = rdy_q;
endmodule

// File: rtl/lsd_ctl_fields.sv
module lsd_ctl_fields
  import lsd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rdy_i,
  input  logic              fail_pulse_i,
  output ctl_fields_t       fields_o,
  output logic              clear_o
);
  ctl_fields_t f_q, f_d;
  logic        clear;
  logic        byp_open;
  logic        src_open;
  logic        mon_may_clear;

  assign clear         = f_q.dom_rst | (wr_en & wr_data[BIT_DOM_RST]);
  assign byp_open      = ~f_q.osc_en & ~rdy_i;
  assign src_open      = (f_q.src == SRC_NONE) | f_q.fail;
  assign mon_may_clear = f_q.fail;

  always_comb begin
    f_d = f_q;
    if (wr_en) begin
      f_d.dom_rst = wr_data[BIT_DOM_RST];
    end
    if (clear) begin
      f_d.osc_en  = 1'b0;
      f_d.byp     = 1'b0;
      f_d.drv     = 2'b00;
      f_d.mon_en  = 1'b0;
      f_d.fail    = 1'b0;
      f_d.src     = SRC_NONE;
      f_d.rtc_en  = 1'b0;
      f_d.lso_en  = 1'b0;
      f_d.lso_sel = 1'b0;
    end else begin
      if (wr_en) begin
        f_d.osc_en  = wr_data[BIT_OSC_EN];
        f_d.drv     = wr_data[DRV_LSB +: 2];
        f_d.rtc_en  = wr_data[BIT_RTC_EN];
        f_d.lso_en  = wr_data[BIT_LSO_EN];
        f_d.lso_sel = wr_data[BIT_LSO_SEL];
        if (byp_open) f_d.byp = wr_data[BIT_BYP];
        if (src_open) f_d.src = rtc_src_e'(wr_data[SRC_LSB +: 2]);
        if (wr_data[BIT_MON])   f_d.mon_en = 1'b1;
        else if (mon_may_clear) f_d.mon_en = 1'b0;
      end
      if (f_q.mon_en && fail_pulse_i) f_d.fail = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) f_q <= '0;
    else        f_q <= f_d;
  end

  assign fields_o = f_q;
  assign clear_o  = clear;
endmodule

// File: rtl/lsd_ctrl_reg.sv
module lsd_ctrl_reg
  import lsd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FALL_EDGES  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_en,
  output logic [REG_W-1:0] rd_data,
  input  logic             osc_stable_i,
  input  logic             lsclk_i,
  input  logic             fail_pulse_i,
  output logic             osc_en_o,
  output logic             osc_byp_o,
  output logic [1:0]       osc_drv_o,
  output logic             mon_en_o,
  output logic [1:0]       rtc_src_o,
  output logic             rtc_en_o,
  output logic             dom_rst_o,
  output logic             lsout_en_o,
  output logic             lsout_sel_o
);
  ctl_fields_t      fields;
  logic             dom_clear;
  logic             ls_rise;
  logic             rdy_flag;
  logic             fail_flag;
  logic [REG_W-1:0] image;
  logic [REG_W-1:0] rd_q, rd_d;

  lsd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (lsclk_i),
    .rise_o  (ls_rise)
  );

  lsd_ready_track #(.FALL_EDGES(FALL_EDGES)) u_ready (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (dom_clear),
    .osc_en_i  (fields.osc_en),
    .stable_i  (osc_stable_i),
    .ls_rise_i (ls_rise),
    .rdy_o     (rdy_flag)
  );

  lsd_ctl_fields u_fields (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .rdy_i        (rdy_flag),
    .fail_pulse_i (fail_pulse_i),
    .fields_o     (fields),
    .clear_o      (dom_clear)
  );

  assign fail_flag = fields.fail;

  always_comb begin
    image                  = '0;
    image[BIT_OSC_EN]      = fields.osc_en;
    image[BIT_RDY]         = rdy_flag;
    image[BIT_BYP]         = fields.byp;
    image[DRV_LSB +: 2]    = fields.drv;
    image[BIT_MON]         = fields.mon_en;
    image[BIT_FAIL]        = fields.fail;
    image[SRC_LSB +: 2]    = fields.src;
    image[BIT_RTC_EN]      = fields.rtc_en;
    image[BIT_DOM_RST]     = fields.dom_rst;
    image[BIT_LSO_EN]      = fields.lso_en;
    image[BIT_LSO_SEL]     = fields.lso_sel;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = image;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data     = rd_q;
  assign osc_en_o    = fields.osc_en;
  assign osc_byp_o   = fields.byp;
  assign osc_drv_o   = fields.drv;
  assign mon_en_o    = fields.mon_en;
  assign rtc_src_o   = fields.src;
  assign rtc_en_o    = fields.rtc_en;
  assign dom_rst_o   = fields.dom_rst;
  assign lsout_en_o  = fields.lso_en;
  assign lsout_sel_o = fields.lso_sel;
endmodule

// File: rtl/lsd_ctrl_reg_checker.sv
module lsd_ctrl_reg_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic        osc_en,
  input logic        osc_byp,
  input logic [1:0]  osc_drv,
  input logic        mon_en,
  input logic [1:0]  rtc_src,
  input logic        rtc_en,
  input logic        dom_rst,
  input logic        lsout_en,
  input logic        lsout_sel,
  input logic        rdy,
  input logic        fail
);
  logic rst_wr;
  assign rst_wr = wr_en & wr_data[16];

  // R4: ready only rises with the enable set
  p_rdy_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(osc_en));

  // R6: bypass frozen while the oscillator is on or ready
  p_byp_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((osc_en || rdy) && !dom_rst && !rst_wr) |=> $stable(osc_byp));

  // R7: locked source select keeps its value
  p_src_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((rtc_src != 2'd0) && !fail && !dom_rst && !rst_wr) |=> $stable(rtc_src));

  // R9: monitor enable cannot drop without a failure
  p_mon_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !fail && !dom_rst && !rst_wr) |=> mon_en);

  // R10: failure flag is sticky
  p_fail_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !dom_rst && !rst_wr) |=> fail);

  // R10: failure never appears without the monitor on
  p_fail_needs_mon_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(mon_en));

  // R11: domain reset holds every other field at zero
  p_dom_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dom_rst |-> (!osc_en && !osc_byp && osc_drv == 2'b00 && !mon_en &&
                 rtc_src == 2'b00 && !rtc_en && !lsout_en && !lsout_sel &&
                 !rdy && !fail));
endmodule

bind lsd_ctrl_reg lsd_ctrl_reg_checker u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .osc_en    (osc_en_o),
  .osc_byp   (osc_byp_o),
  .osc_drv   (osc_drv_o),
  .mon_en    (mon_en_o),
  .rtc_src   (rtc_src_o),
  .rtc_en    (rtc_en_o),
  .dom_rst   (dom_rst_o),
  .lsout_en  (lsout_en_o),
  .lsout_sel (lsout_sel_o),
  .rdy       (rdy_flag),
  .fail      (fail_flag)
);

// File: tb/lsd_ctrl_reg_bench.sv
module lsd_ctrl_reg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic        osc_stable_i = 1'b0;
  logic        lsclk_i = 1'b0;
  logic        fail_pulse_i = 1'b0;
  logic        osc_en_o, osc_byp_o, mon_en_o, rtc_en_o, dom_rst_o;
  logic        lsout_en_o, lsout_sel_o;
  logic [1:0]  osc_drv_o, rtc_src_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lsd_ctrl_reg u_lsd_ctrl_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .osc_stable_i(osc_stable_i),
    .lsclk_i(lsclk_i), .fail_pulse_i(fail_pulse_i),
    .osc_en_o(osc_en_o), .osc_byp_o(osc_byp_o), .osc_drv_o(osc_drv_o),
    .mon_en_o(mon_en_o), .rtc_src_o(rtc_src_o), .rtc_en_o(rtc_en_o),
    .dom_rst_o(dom_rst_o), .lsout_en_o(lsout_en_o), .lsout_sel_o(lsout_sel_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic ls_edge();
    @(negedge clk); lsclk_i = 1'b1;
    idle(4);
    lsclk_i = 1'b0;
    idle(4);
  endtask

  task automatic fail_pulse();
    @(negedge clk); fail_pulse_i = 1'b1;
    @(negedge clk); fail_pulse_i = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(v);
    check("R1 word after reset", v, 32'h0);
    check("R1 outputs after reset",
          {22'd0, osc_en_o, osc_byp_o, osc_drv_o, mon_en_o, rtc_src_o,
           rtc_en_o, dom_rst_o, lsout_en_o, lsout_sel_o}, 32'h0);
  endtask

  task automatic t_free_fields();
    logic [31:0] v;
    wr(32'h8300_9053 | 32'h0000_0002);
    rd(v);
    check("R2 free fields and reserved bits", v, 32'h0300_8011);
    check("R10 bit 6 write ignored", {31'd0, v[6]}, 32'h0);
    check("R12 drive output", {30'd0, osc_drv_o}, 32'h2);
    check("R12 misc outputs", {28'd0, osc_en_o, rtc_en_o, lsout_en_o, lsout_sel_o}, 32'hF);
    wr(32'h0);
  endtask

  task automatic t_read_latency();
    logic [31:0] v;
    wr(32'h0100_0000);
    rd(v);
    check("R3 read value", v, 32'h0100_0000);
    wr(32'h0000_8000);
    idle(2);
    check("R3 rd_data held without rd_en", rd_data, 32'h0100_0000);
    rd(v);
    check("R3 new read value", v, 32'h0000_8000);
    wr(32'h0);
  endtask

  task automatic t_ready_cycle();
    logic [31:0] v;
    osc_stable_i = 1'b1;
    idle(3);
    rd(v);
    check("R4 no ready while disabled", {31'd0, v[1]}, 32'h0);
    wr(32'h1);
    idle(2);
    rd(v);
    check("R4 ready rises with enable", {31'd0, v[1]}, 32'h1);
    wr(32'h5);
    rd(v);
    check("R6 bypass blocked while enabled", {31'd0, v[2]}, 32'h0);
    osc_stable_i = 1'b0;
    wr(32'h0);
    wr(32'h4);
    rd(v);
    check("R6 bypass blocked while ready high", {31'd0, v[2]}, 32'h0);
    for (int e = 0; e < 5; e++) ls_edge();
    rd(v);
    check("R5 ready kept through five edges", {31'd0, v[1]}, 32'h1);
    ls_edge();
    rd(v);
    check("R5 ready drops on sixth edge", {31'd0, v[1]}, 32'h0);
    wr(32'h4);
    rd(v);
    check("R6 bypass accepted when off", v, 32'h4);
    check("R12 bypass output", {31'd0, osc_byp_o}, 32'h1);
    wr(32'h0);
  endtask

  task automatic t_src_lock();
    logic [31:0] v;
    wr(32'h200);
    rd(v);
    check("R7 first source write", v, 32'h200);
    wr(32'h300);
    rd(v);
    check("R7 second source write ignored", v, 32'h200);
    wr(32'h000);
    rd(v);
    check("R7 zero write ignored", v, 32'h200);
    check("R12 source output", {30'd0, rtc_src_o}, 32'h2);
  endtask

  task automatic t_monitor();
    logic [31:0] v;
    fail_pulse();
    rd(v);
    check("R10 pulse ignored with monitor off", {31'd0, v[6]}, 32'h0);
    wr(32'h220);
    wr(32'h200);
    rd(v);
    check("R9 monitor clear ignored", v, 32'h220);
    fail_pulse();
    idle(2);
    rd(v);
    check("R10 failure captured", v, 32'h260);
    wr(32'h320);
    rd(v);
    check("R8 source rewritable during failure", v, 32'h360);
    wr(32'h300);
    rd(v);
    check("R9 monitor cleared after failure", v, 32'h340);
  endtask

  task automatic t_domain_reset();
    logic [31:0] v;
    wr(32'h0301_8025);
    rd(v);
    check("R11 reset clears other fields", v, 32'h0001_0000);
    check("R12 reset output", {31'd0, dom_rst_o}, 32'h1);
    wr(32'h0001_8321);
    rd(v);
    check("R11 writes ignored during reset", v, 32'h0001_0000);
    wr(32'h0);
    rd(v);
    check("R11 failure cleared after reset", v, 32'h0);
    wr(32'h100);
    rd(v);
    check("R7 source unlocked after reset", v, 32'h100);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_free_fields();
    t_read_latency();
    t_ready_cycle();
    t_src_lock();
    t_monitor();
    t_domain_reset();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule